// File: doc/BRIEF.md
# Pointer-Addressed Two-Wire Register Target

This block is a receive-only target for a two-wire serial bus of the SMBus/I2C kind. It samples the clock and data lines through a synchronizer and recognises the start and stop conditions. After each start it collects one address byte. If the seven address bits select this target, it acknowledges and then either takes bytes in or sends register contents out, depending on the direction bit. It drives the data line only by pulling it low. The output is an enable for an external open-drain pad.

Internal 8-bit registers are reached through a retained pointer. In a write transaction, the first byte after the address sets the pointer. Any further bytes go to the register the pointer selects, and the pointer advances by one after each of them. A read transaction returns the register at the current pointer. The pointer stays where it is until a later write sets it or advances it. The register file sits outside the block. The block reaches it through an address, write-data, write-strobe and read-strobe interface, and the read data comes back on a combinational input.

Top module: `smb_ptr_slave`

## Requirements
- R1: After reset the data-line pull-down enable `sda_oe` is low and `reg_we` is low.
- R2: A falling data line while the clock is high starts a transaction. The next eight clock-high samples form the address byte, MSB first: seven address bits, then a direction bit (0 = write, 1 = read). With `ADDR_ALT`=0 the address 7'h4C is acknowledged by holding data low for the whole ninth clock.
- R3: If the address does not match, the target leaves the data line released and strobes no register until the next start condition.
- R4: With `ADDR_ALT`=1 the target acknowledges 7'h4D and does not acknowledge 7'h4C.
- R5: The first byte of a write transaction is acknowledged and loads the pointer. A write made of only that byte writes no register.
- R6: Each later write byte is acknowledged, appears on `reg_wdata` with `reg_addr` equal to the pointer during a one-cycle `reg_we` pulse, and then the pointer increments by one.
- R7: A read returns the register selected by the pointer, MSB first. The driven level stays constant while the clock is high.
- R8: Reads do not move the pointer. Repeated read transactions, and further acknowledged bytes within one read, return the same register.
- R9: After the controller answers a read byte with a not-acknowledge, the target keeps the data line released through any further clocks.
- R10: A repeated start mid-transaction returns the target to the address phase. A stop returns it to idle, and clocks after that are ignored until a new start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 = pull the data line low |
| reg_addr | output | PTR_W | Register select (pointer, or write address during `reg_we`) |
| reg_wdata | output | 8 | Write data |
| reg_we | output | 1 | One-cycle write strobe |
| reg_rd | output | 1 | One-cycle strobe when read data is taken |
| reg_rdata | input | 8 | Read data for `reg_addr` |

## Verification
Every result of the block follows a bus-clock edge after a fixed delay. The default two-stage synchronizer takes two system clocks, and the control register takes one more. So an acknowledge or a data bit is on `sda_oe` three clocks after the falling clock edge, and a write strobe comes three clocks after the eighth rising edge. The bench model of the bus controller holds each bus phase for eight system clocks. It samples the wired-AND data line only in the middle of the clock-high phase, and again near its end for the stability check. It checks register contents only after the stop, so every result is sampled well after it is due.

// File: rtl/smb_ptr_pkg.sv
package smb_ptr_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_ACK_SET,
      ST_ACK_HOLD,
      ST_WR,
      ST_RD,
      ST_RD_ACK,
      ST_IGNORE
   } smb_st_e;

   localparam logic [6:0] SLV_ADDR_MAIN = 7'b1001100;
   localparam logic [6:0] SLV_ADDR_ALT  = 7'b1001101;

endpackage

// File: rtl/smb_ptr_sync.sv
module smb_ptr_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_s,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("smb_ptr_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] scl_ff;
   logic [STAGES-1:0] sda_ff;
   logic              scl_q;
   logic              sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_ff <= '1;
         sda_ff <= '1;
         scl_q  <= 1'b1;
         sda_q  <= 1'b1;
      end else begin
         scl_ff <= {scl_ff[STAGES-2:0], scl_i};
         sda_ff <= {sda_ff[STAGES-2:0], sda_i};
         scl_q  <= scl_ff[STAGES-1];
         sda_q  <= sda_ff[STAGES-1];
      end
   end

   assign scl_s     = scl_ff[STAGES-1];
   assign sda_s     = sda_ff[STAGES-1];
   assign scl_rise  = scl_s & ~scl_q;
   assign scl_fall  = ~scl_s & scl_q;
   assign start_det = scl_s & scl_q & sda_q & ~sda_s;
   assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/smb_ptr_addr_match.sv
module smb_ptr_addr_match
   import smb_ptr_pkg::*;
#(
   parameter bit ADDR_ALT = 1'b0
) (
   input  logic [7:0] addr_byte,
   output logic       hit,
   output logic       dir_rd
);

   logic [6:0] own_addr;

   generate
      if (ADDR_ALT) begin : g_alt
         assign own_addr = SLV_ADDR_ALT;
      end else begin : g_main
         assign own_addr = SLV_ADDR_MAIN;
      end
   endgenerate

   assign hit    = (addr_byte[7:1] == own_addr);
   assign dir_rd = addr_byte[0];

endmodule

// File: rtl/smb_ptr_ctrl.sv
module smb_ptr_ctrl
   import smb_ptr_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int PTR_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_s,
   input  logic              sda_s,
   input  logic              scl_rise,
   input  logic              scl_fall,
   input  logic              start_det,
   input  logic              stop_det,
   input  logic              addr_hit,
   input  logic              addr_rd,
   output logic [DATA_W-1:0] shift_next,
   output logic              sda_oe,
   output logic [PTR_W-1:0]  reg_addr,
   output logic [DATA_W-1:0] reg_wdata,
   output logic              reg_we,
   output logic              reg_rd,
   input  logic [DATA_W-1:0] reg_rdata
);

   localparam int CNT_W = $clog2(DATA_W);
   localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

   generate
      if (DATA_W != 8) begin : g_bad_width
         $error("smb_ptr_ctrl: DATA_W must be 8");
      end
      if (PTR_W < 1 || PTR_W > DATA_W) begin : g_bad_ptr
         $error("smb_ptr_ctrl: PTR_W must be within 1..DATA_W");
      end
   endgenerate

   smb_st_e            state;
   logic [CNT_W-1:0]   cnt;
   logic [DATA_W-1:0]  sh;
   logic               dir_q;
   logic               first_q;
   logic [PTR_W-1:0]   ptr;
   logic [PTR_W-1:0]   waddr;
   logic               load_rd;

   assign shift_next = {sh[DATA_W-2:0], sda_s};
   assign load_rd    = (state == ST_ACK_HOLD) && scl_fall && dir_q
                       && !start_det && !stop_det;
   assign reg_rd     = load_rd;
   assign reg_addr   = reg_we ? waddr : ptr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         cnt       <= '0;
         sh        <= '0;
         dir_q     <= 1'b0;
         first_q   <= 1'b0;
         ptr       <= '0;
         waddr     <= '0;
         reg_wdata <= '0;
         reg_we    <= 1'b0;
         sda_oe    <= 1'b0;
      end else begin
         reg_we <= 1'b0;
         if (start_det) begin
            state  <= ST_ADDR;
            cnt    <= '0;
            sda_oe <= 1'b0;
         end else if (stop_det) begin
            state  <= ST_IDLE;
            sda_oe <= 1'b0;
         end else begin
            unique case (state)
               ST_ADDR: begin
                  if (scl_rise) begin
                     sh  <= shift_next;
                     cnt <= cnt + 1'b1;
                     if (cnt == LAST_BIT) begin
                        if (addr_hit) begin
                           dir_q   <= addr_rd;
                           first_q <= 1'b1;
                           state   <= ST_ACK_SET;
                        end else begin
                           state <= ST_IGNORE;
                        end
                     end
                  end
               end
               ST_ACK_SET: begin
                  if (scl_fall) begin
                     sda_oe <= 1'b1;
                     state  <= ST_ACK_HOLD;
                  end
               end
               ST_ACK_HOLD: begin
                  if (scl_fall) begin
                     cnt <= '0;
                     if (dir_q) begin
                        sh     <= reg_rdata;
                        sda_oe <= ~reg_rdata[DATA_W-1];
                        state  <= ST_RD;
                     end else begin
                        sda_oe <= 1'b0;
                        state  <= ST_WR;
                     end
                  end
               end
               ST_WR: begin
                  if (scl_rise) begin
                     sh  <= shift_next;
                     cnt <= cnt + 1'b1;
                     if (cnt == LAST_BIT) begin
                        state <= ST_ACK_SET;
                        if (first_q) begin
                           ptr     <= shift_next[PTR_W-1:0];
                           first_q <= 1'b0;
                        end else begin
                           reg_we    <= 1'b1;
                           waddr     <= ptr;
                           reg_wdata <= shift_next;
                           ptr       <= ptr + 1'b1;
                        end
                     end
                  end
               end
               ST_RD: begin
                  if (scl_fall) begin
                     if (cnt == LAST_BIT) begin
                        sda_oe <= 1'b0;
                        cnt    <= '0;
                        state  <= ST_RD_ACK;
                     end else begin
                        sh     <= {sh[DATA_W-2:0], 1'b0};
                        sda_oe <= ~sh[DATA_W-2];
                        cnt    <= cnt + 1'b1;
                     end
                  end
               end
               ST_RD_ACK: begin
                  if (scl_rise) begin
                     state <= sda_s ? ST_IGNORE : ST_ACK_HOLD;
                  end
               end
               default: ;
            endcase
         end
      end
   end

   // R3 / R9: a target that has stepped off the bus never pulls the line
   assert_ignore_released_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IGNORE) |-> !sda_oe);

   // R6: the write strobe lasts one cycle
   assert_we_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
      reg_we |=> !reg_we);

   // R2 / R10: a start condition always leads into the address phase, line released
   assert_start_addr_R10: assert property (@(posedge clk) disable iff (!rst_n)
      start_det |=> (state == ST_ADDR) && !sda_oe);

   // R10: a stop condition returns to idle
   assert_stop_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_det && !start_det) |=> (state == ST_IDLE) && !sda_oe);

   // R7: the driven level changes only after the clock was seen low
   assert_oe_stable_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(scl_s) && !$past(start_det) && !$past(stop_det)) |-> (sda_oe == $past(sda_oe)));

   // R8: sending read data leaves the pointer alone
   assert_ptr_held_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_RD) |=> $stable(ptr));

endmodule

// File: rtl/smb_ptr_slave.sv
module smb_ptr_slave #(
   parameter bit ADDR_ALT    = 1'b0,
   parameter int SYNC_STAGES = 2,
   parameter int PTR_W       = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             scl_i,
   input  logic             sda_i,
   output logic             sda_oe,
   output logic [PTR_W-1:0] reg_addr,
   output logic [7:0]       reg_wdata,
   output logic             reg_we,
   output logic             reg_rd,
   input  logic [7:0]       reg_rdata
);

   localparam int DATA_W = 8;

   logic             scl_s;
   logic             sda_s;
   logic             scl_rise;
   logic             scl_fall;
   logic             start_det;
   logic             stop_det;
   logic             addr_hit;
   logic             addr_rd;
   logic [DATA_W-1:0] shift_next;

   smb_ptr_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_i     (scl_i),
      .sda_i     (sda_i),
      .scl_s     (scl_s),
      .sda_s     (sda_s),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det)
   );

   smb_ptr_addr_match #(.ADDR_ALT(ADDR_ALT)) u_match (
      .addr_byte (shift_next),
      .hit       (addr_hit),
      .dir_rd    (addr_rd)
   );

   smb_ptr_ctrl #(.DATA_W(DATA_W), .PTR_W(PTR_W)) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .scl_s      (scl_s),
      .sda_s      (sda_s),
      .scl_rise   (scl_rise),
      .scl_fall   (scl_fall),
      .start_det  (start_det),
      .stop_det   (stop_det),
      .addr_hit   (addr_hit),
      .addr_rd    (addr_rd),
      .shift_next (shift_next),
      .sda_oe     (sda_oe),
      .reg_addr   (reg_addr),
      .reg_wdata  (reg_wdata),
      .reg_we     (reg_we),
      .reg_rd     (reg_rd),
      .reg_rdata  (reg_rdata)
   );

endmodule

// File: tb/sim_smb_ptr_slave.sv
module sim_smb_ptr_slave;

   localparam int CLK_PERIOD = 10;
   localparam int QTR        = 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       scl_m = 1'b1;
   logic       sda_m = 1'b1;
   logic       oe0, oe1;
   logic       sda_line;
   logic [7:0] addr0, wdata0, addr1, wdata1;
   logic       we0, rd0, we1, rd1;
   logic [7:0] regs [0:255];
   int         checks = 0;
   int         errors = 0;
   int         we_cnt = 0;
   int         oe0_cnt = 0;
   int         oe1_cnt = 0;
   int         unstable = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   assign sda_line = sda_m & ~oe0 & ~oe1;

   smb_ptr_slave u0 (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
      .sda_oe(oe0), .reg_addr(addr0), .reg_wdata(wdata0),
      .reg_we(we0), .reg_rd(rd0), .reg_rdata(regs[addr0])
   );

   smb_ptr_slave #(.ADDR_ALT(1'b1)) u1 (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
      .sda_oe(oe1), .reg_addr(addr1), .reg_wdata(wdata1),
      .reg_we(we1), .reg_rd(rd1), .reg_rdata(8'hA5)
   );

   always @(posedge clk) begin
      if (we0) begin
         regs[addr0] <= wdata0;
         we_cnt <= we_cnt + 1;
      end
      if (oe0) oe0_cnt <= oe0_cnt + 1;
      if (oe1) oe1_cnt <= oe1_cnt + 1;
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_start;
      sda_m = 1'b1; wait_clk(QTR);
      scl_m = 1'b1; wait_clk(QTR);
      sda_m = 1'b0; wait_clk(QTR);
      scl_m = 1'b0; wait_clk(QTR);
   endtask

   task automatic bus_stop;
      sda_m = 1'b0; wait_clk(QTR);
      scl_m = 1'b1; wait_clk(QTR);
      sda_m = 1'b1; wait_clk(QTR);
   endtask

   task automatic send_byte(input logic [7:0] b, output bit acked);
      for (int i = 7; i >= 0; i--) begin
         sda_m = b[i]; wait_clk(QTR);
         scl_m = 1'b1; wait_clk(2*QTR);
         scl_m = 1'b0;
      end
      sda_m = 1'b1; wait_clk(QTR);
      scl_m = 1'b1; wait_clk(QTR);
      acked = (sda_line == 1'b0);
      wait_clk(QTR);
      scl_m = 1'b0; wait_clk(QTR);
   endtask

   task automatic get_byte(input bit ack, output logic [7:0] b);
      logic s0;
      sda_m = 1'b1;
      for (int i = 7; i >= 0; i--) begin
         wait_clk(QTR);
         scl_m = 1'b1; wait_clk(QTR);
         s0 = sda_line; b[i] = s0;
         wait_clk(QTR - 1);
         if (sda_line != s0) unstable++;
         wait_clk(1);
         scl_m = 1'b0;
      end
      sda_m = ack ? 1'b0 : 1'b1;
      wait_clk(QTR);
      scl_m = 1'b1; wait_clk(2*QTR);
      scl_m = 1'b0; wait_clk(1);
      sda_m = 1'b1;
   endtask

   task automatic t_reset;
      check(oe0 == 1'b0 && oe1 == 1'b0, "R1 sda_oe after reset", oe0, 0);
      check(we0 == 1'b0, "R1 reg_we after reset", we0, 0);
   endtask

   task automatic t_write_multi;
      bit a;
      int w0;
      w0 = we_cnt;
      bus_start;
      send_byte(8'h98, a); check(a, "R2 address 4Ch write ack", a, 1);
      send_byte(8'h10, a); check(a, "R5 pointer byte ack", a, 1);
      send_byte(8'hAA, a); check(a, "R6 data byte ack", a, 1);
      send_byte(8'h55, a); check(a, "R6 second data byte ack", a, 1);
      bus_stop;
      wait_clk(4);
      check(regs[8'h10] == 8'hAA, "R6 reg 10h written", regs[8'h10], 8'hAA);
      check(regs[8'h11] == 8'h55, "R6 reg 11h after increment", regs[8'h11], 8'h55);
      check(we_cnt - w0 == 2, "R6 strobe count", we_cnt - w0, 2);
   endtask

   task automatic t_read_after_incr;
      bit a;
      logic [7:0] d;
      bus_start;
      send_byte(8'h99, a); check(a, "R2 address 4Ch read ack", a, 1);
      get_byte(1'b0, d);
      bus_stop;
      check(d == 8'h77, "R6 pointer advanced to 12h", d, 8'h77);
   endtask

   task automatic t_ptr_only_read;
      bit a;
      int w0;
      logic [7:0] d;
      w0 = we_cnt;
      bus_start;
      send_byte(8'h98, a);
      send_byte(8'h20, a); check(a, "R5 pointer-only ack", a, 1);
      bus_stop;
      wait_clk(4);
      check(we_cnt == w0, "R5 pointer-only writes nothing", we_cnt - w0, 0);
      unstable = 0;
      bus_start;
      send_byte(8'h99, a);
      get_byte(1'b0, d);
      bus_stop;
      check(d == 8'h3C, "R7 read pointed register", d, 8'h3C);
      check(unstable == 0, "R7 data stable while clock high", unstable, 0);
   endtask

   task automatic t_retained;
      bit a;
      logic [7:0] d0, d1, d2;
      bus_start;
      send_byte(8'h99, a);
      get_byte(1'b1, d0);
      get_byte(1'b0, d1);
      oe0_cnt = 0;
      get_byte(1'b0, d2);
      check(oe0_cnt == 0, "R9 released after not-acknowledge", oe0_cnt, 0);
      check(d2 == 8'hFF, "R9 idle line reads ones", d2, 8'hFF);
      bus_stop;
      check(d0 == 8'h3C, "R8 first byte same register", d0, 8'h3C);
      check(d1 == 8'h3C, "R8 acked byte repeats register", d1, 8'h3C);
   endtask

   task automatic t_restart;
      bit a;
      logic [7:0] d;
      bus_start;
      send_byte(8'h98, a);
      send_byte(8'h30, a);
      bus_start;
      send_byte(8'h99, a); check(a, "R10 address after repeated start", a, 1);
      get_byte(1'b0, d);
      bus_stop;
      check(d == 8'hC3, "R10 read after repeated start", d, 8'hC3);
   endtask

   task automatic t_mismatch;
      bit a;
      int w0;
      w0 = we_cnt;
      oe0_cnt = 0; oe1_cnt = 0;
      bus_start;
      send_byte(8'h90, a); check(!a, "R3 foreign address not acked", a, 0);
      send_byte(8'h00, a);
      send_byte(8'h00, a);
      bus_stop;
      wait_clk(4);
      check(oe0_cnt == 0 && oe1_cnt == 0, "R3 line never pulled", oe0_cnt + oe1_cnt, 0);
      check(we_cnt == w0, "R3 no register strobe", we_cnt - w0, 0);
   endtask

   task automatic t_alt;
      bit a;
      logic [7:0] d;
      oe0_cnt = 0;
      bus_start;
      send_byte(8'h9A, a); check(a, "R4 alternate address acked", a, 1);
      send_byte(8'h05, a);
      bus_start;
      send_byte(8'h9B, a);
      get_byte(1'b0, d);
      bus_stop;
      check(d == 8'hA5, "R4 data from alternate target", d, 8'hA5);
      check(oe0_cnt == 0, "R4 default target silent on 4Dh", oe0_cnt, 0);
      oe1_cnt = 0;
      bus_start;
      send_byte(8'h98, a);
      bus_stop;
      check(oe1_cnt == 0, "R4 alternate target ignores 4Ch", oe1_cnt, 0);
   endtask

   task automatic t_after_stop;
      bit a;
      oe0_cnt = 0;
      send_byte(8'h98, a);
      check(!a && oe0_cnt == 0, "R10 clocks after stop ignored", oe0_cnt, 0);
   endtask

   bit done = 1'b0;

   initial begin
      for (int i = 0; i < 256; i++) regs[i] = 8'h00;
      regs[8'h12] = 8'h77;
      regs[8'h20] = 8'h3C;
      regs[8'h30] = 8'hC3;
      wait_clk(5);
      t_reset;
      rst_n = 1'b1;
      wait_clk(5);
      t_write_multi;
      t_read_after_incr;
      t_ptr_only_read;
      t_retained;
      t_restart;
      t_mismatch;
      t_alt;
      t_after_stop;
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule